// File: doc/BRIEF.md
# Serial Management Status Receiver

This block listens to the per-packet serial management stream that a repeater controller emits. The stream has three inputs: a bit clock, NRZ data that changes on the falling clock edge, and a carrier-sense signal that frames each packet. The polarity of carrier sense is programmable. All three inputs are brought into the system clock domain through a synchronizer. Bits are taken on each rising edge of the stream clock.

Inside each carrier envelope the block first searches for the start-of-frame delimiter. It then shifts every later bit into a 56-bit window. When carrier drops, the window holds the trailing seven status bytes. Those bytes are judged on three points:

- whether the stream was long enough;
- whether the controller ID matches one of two programmed IDs;
- whether the port number is in range.

Good status is offered to a downstream attribute engine over a valid/ready handshake, together with the index of the matching ID. Faulty frames raise single-cycle error pulses instead.

Top module: `mgmt_status_rx`

## Requirements
- R1: Serial data is captured on rising edges of `mrx_clk` only; the bench changes `mrx_data` on falling edges.
- R2: `cfg_crs_high`=1 makes a high `mrx_crs` mean carrier present; `cfg_crs_high`=0 makes a low level mean carrier present. Polarity is changed only while `cfg_start` is 0.
- R3: The delivered status is the last 56 bits received after the delimiter and before carrier drops, however many bits came before them. Each byte arrives least significant bit first. Status byte k sits at `st_bytes[8k+7:8k]`. Byte 0 bits [5:0] hold the controller ID and byte 1 bits [3:0] hold the port number.
- R4: The delimiter is the byte 0xD5 received least significant bit first (1,0,1,0,1,0,1,1). The search starts at the leading edge of carrier and stops once the delimiter is found. A frame without a delimiter gives a one-cycle `err_bus` pulse and no status.
- R5: A frame with fewer than 56 bits after the delimiter gives a one-cycle `err_bus` pulse and no status. Exactly 56 bits is accepted.
- R6: Status is accepted only if its ID equals `cfg_id0` or `cfg_id1`. A match on `cfg_id0` gives `st_sel`=0 and takes priority. A match on `cfg_id1` only gives `st_sel`=1. A frame matching neither is dropped with no output and no error.
- R7: A matching frame with a port number above 13 gives a one-cycle `err_port` pulse and no status. Port 13 is accepted.
- R8: A carrier envelope that begins while `cfg_start` is 0 is ignored completely: no status and no error.
- R9: While `st_valid` is high and `st_ready` is low, `st_valid`, `st_bytes` and `st_sel` hold.
  - A new good frame judged in that state is discarded.
  - A new good frame judged in the same cycle that the held status is accepted replaces it, and `st_valid` stays high.
- R10: `err_bus` and `err_port` are single-cycle pulses and never assert together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the stream clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Enables acceptance of new carrier envelopes |
| cfg_crs_high | input | 1 | Carrier-sense polarity, 1 = active high |
| cfg_id0 | input | 6 | First accepted controller ID |
| cfg_id1 | input | 6 | Second accepted controller ID |
| mrx_clk | input | 1 | Serial stream clock (asynchronous) |
| mrx_data | input | 1 | Serial NRZ data (asynchronous) |
| mrx_crs | input | 1 | Carrier-sense framing (asynchronous) |
| st_valid | output | 1 | Status bytes available |
| st_ready | input | 1 | Downstream accepts status |
| st_bytes | output | 56 | Seven status bytes, byte 0 in the low bits |
| st_sel | output | 1 | Index of the matching controller ID |
| err_bus | output | 1 | Missing delimiter or short status pulse |
| err_port | output | 1 | Invalid port number pulse |

## Verification
The two functions that can fall in the same cycle are the downstream acceptance of held status and the judging of the next frame's status. The bench holds the first status with ready low and ends a second frame. It then raises ready for a single cycle at each offset from zero to six cycles after carrier drops. The offsets are counted through the synchronizer, the frame-end register and the output register. When the pulse lands at or before the cycle in which the new status is judged, the first status must be accepted and the second must remain valid. When it lands later, the second must be gone and only the first accepted.

// File: rtl/mrx_pkg.sv
`timescale 1ns/1ps
package mrx_pkg;
    localparam int BYTE_W       = 8;
    localparam int STATUS_BYTES = 7;
    localparam int STATUS_BITS  = STATUS_BYTES * BYTE_W;
    localparam int ID_W         = 6;
    localparam int PORT_W       = 4;
    localparam int MAX_PORT     = 13;
    localparam int SYNC_STAGES  = 2;
    localparam logic [BYTE_W-1:0] SFD_PATTERN = 8'hD5;
endpackage

// File: rtl/mrx_sync.sv
`timescale 1ns/1ps
module mrx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef logic [WIDTH-1:0] vec_t;
    vec_t stage_d [STAGES];
    vec_t stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/mrx_framer.sv
`timescale 1ns/1ps
module mrx_framer
    import mrx_pkg::*;
#(
    parameter int BITS = STATUS_BITS,
    parameter logic [BYTE_W-1:0] SFD = SFD_PATTERN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_start,
    input  logic            cfg_crs_high,
    input  logic            sclk_s,
    input  logic            sdat_s,
    input  logic            scrs_s,
    output logic            frame_done,
    output logic            frame_ok,
    output logic [BITS-1:0] frame_bits
);
    localparam int CNT_W = $clog2(BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BITS);

    typedef struct packed {
        logic              clk_prev;
        logic              act_prev;
        logic              in_frame;
        logic              sfd_seen;
        logic [BYTE_W-1:0] win;
        logic [CNT_W-1:0]  cnt;
        logic [BITS-1:0]   sh;
        logic              done;
        logic              ok;
    } fr_t;

    fr_t fr_d, fr_q;
    logic act, clk_rise;

    always_comb begin
        fr_d     = fr_q;
        fr_d.done = 1'b0;
        act      = cfg_crs_high ? scrs_s : ~scrs_s;
        clk_rise = sclk_s & ~fr_q.clk_prev;
        fr_d.clk_prev = sclk_s;
        fr_d.act_prev = act;
        if (!fr_q.in_frame) begin
            // a new envelope is accepted only at its leading edge
            if (act && !fr_q.act_prev && cfg_start) begin
                fr_d.in_frame = 1'b1;
                fr_d.sfd_seen = 1'b0;
                fr_d.win      = '0;
                fr_d.cnt      = '0;
            end
        end else if (!act) begin
            fr_d.in_frame = 1'b0;
            fr_d.done     = 1'b1;
            fr_d.ok       = fr_q.sfd_seen && (fr_q.cnt == FULL);
        end else if (clk_rise) begin
            if (fr_q.sfd_seen) begin
                fr_d.sh = {sdat_s, fr_q.sh[BITS-1:1]};
                if (fr_q.cnt != FULL) begin
                    fr_d.cnt = fr_q.cnt + 1'b1;
                end
            end else begin
                fr_d.win = {sdat_s, fr_q.win[BYTE_W-1:1]};
                if (fr_d.win == SFD) begin
                    fr_d.sfd_seen = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign frame_done = fr_q.done;
    assign frame_ok   = fr_q.ok;
    assign frame_bits = fr_q.sh;
endmodule

// File: rtl/mrx_judge.sv
`timescale 1ns/1ps
module mrx_judge
    import mrx_pkg::*;
#(
    parameter int BITS  = STATUS_BITS,
    parameter int IDW   = ID_W,
    parameter int PW    = PORT_W,
    parameter int PMAX  = MAX_PORT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDW-1:0]  cfg_id0,
    input  logic [IDW-1:0]  cfg_id1,
    input  logic            frame_done,
    input  logic            frame_ok,
    input  logic [BITS-1:0] frame_bits,
    input  logic            st_ready,
    output logic            st_valid,
    output logic [BITS-1:0] st_bytes,
    output logic            st_sel,
    output logic            err_bus,
    output logic            err_port
);
    localparam logic [PW-1:0] PORT_LIMIT = PW'(PMAX);

    typedef struct packed {
        logic            valid;
        logic            sel;
        logic [BITS-1:0] bytes;
        logic            e_bus;
        logic            e_port;
    } jd_t;

    jd_t jd_d, jd_q;
    logic [IDW-1:0] rx_id;
    logic [PW-1:0]  rx_port;
    logic           hit0, hit1;

    always_comb begin
        jd_d        = jd_q;
        jd_d.e_bus  = 1'b0;
        jd_d.e_port = 1'b0;
        rx_id   = frame_bits[IDW-1:0];
        rx_port = frame_bits[BYTE_W+PW-1:BYTE_W];
        hit0    = (rx_id == cfg_id0);
        hit1    = (rx_id == cfg_id1);
        if (jd_q.valid && st_ready) begin
            jd_d.valid = 1'b0;
        end
        if (frame_done) begin
            if (!frame_ok) begin
                jd_d.e_bus = 1'b1;
            end else if (hit0 || hit1) begin
                if (rx_port > PORT_LIMIT) begin
                    jd_d.e_port = 1'b1;
                end else if (!jd_q.valid || st_ready) begin
                    jd_d.valid = 1'b1;
                    jd_d.sel   = ~hit0;
                    jd_d.bytes = frame_bits;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            jd_q <= '0;
        end else begin
            jd_q <= jd_d;
        end
    end

    assign st_valid = jd_q.valid;
    assign st_bytes = jd_q.bytes;
    assign st_sel   = jd_q.sel;
    assign err_bus  = jd_q.e_bus;
    assign err_port = jd_q.e_port;
endmodule

// File: rtl/mgmt_status_rx.sv
`timescale 1ns/1ps
module mgmt_status_rx
    import mrx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_start,
    input  logic                   cfg_crs_high,
    input  logic [ID_W-1:0]        cfg_id0,
    input  logic [ID_W-1:0]        cfg_id1,
    input  logic                   mrx_clk,
    input  logic                   mrx_data,
    input  logic                   mrx_crs,
    output logic                   st_valid,
    input  logic                   st_ready,
    output logic [STATUS_BITS-1:0] st_bytes,
    output logic                   st_sel,
    output logic                   err_bus,
    output logic                   err_port
);
    logic [2:0]             synced;
    logic                   fr_done, fr_ok;
    logic [STATUS_BITS-1:0] fr_bits;

    mrx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({mrx_crs, mrx_data, mrx_clk}),
        .sync_out (synced)
    );

    mrx_framer #(.BITS(STATUS_BITS), .SFD(SFD_PATTERN)) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_start    (cfg_start),
        .cfg_crs_high (cfg_crs_high),
        .sclk_s       (synced[0]),
        .sdat_s       (synced[1]),
        .scrs_s       (synced[2]),
        .frame_done   (fr_done),
        .frame_ok     (fr_ok),
        .frame_bits   (fr_bits)
    );

    mrx_judge #(.BITS(STATUS_BITS), .IDW(ID_W), .PW(PORT_W), .PMAX(MAX_PORT)) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_id0    (cfg_id0),
        .cfg_id1    (cfg_id1),
        .frame_done (fr_done),
        .frame_ok   (fr_ok),
        .frame_bits (fr_bits),
        .st_ready   (st_ready),
        .st_valid   (st_valid),
        .st_bytes   (st_bytes),
        .st_sel     (st_sel),
        .err_bus    (err_bus),
        .err_port   (err_port)
    );
endmodule

// File: rtl/mgmt_status_rx_chk.sv
`timescale 1ns/1ps
module mgmt_status_rx_chk
    import mrx_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic [ID_W-1:0]        cfg_id0,
    input logic [ID_W-1:0]        cfg_id1,
    input logic                   st_valid,
    input logic                   st_ready,
    input logic [STATUS_BITS-1:0] st_bytes,
    input logic                   st_sel,
    input logic                   err_bus,
    input logic                   err_port
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_bytes) && $stable(st_sel)));

    assert_pulse_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_bus |=> !err_bus);

    assert_pulse_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_port |=> !err_port);

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_bus && err_port));

    assert_port_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_valid) |-> (st_bytes[BYTE_W+PORT_W-1:BYTE_W] <= PORT_W'(MAX_PORT)));

    assert_id_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_valid) |-> ((st_bytes[ID_W-1:0] == cfg_id0) || (st_bytes[ID_W-1:0] == cfg_id1)));

    assert_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_valid) |-> (st_sel == (st_bytes[ID_W-1:0] != cfg_id0)));
endmodule

bind mgmt_status_rx mgmt_status_rx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_id0  (cfg_id0),
    .cfg_id1  (cfg_id1),
    .st_valid (st_valid),
    .st_ready (st_ready),
    .st_bytes (st_bytes),
    .st_sel   (st_sel),
    .err_bus  (err_bus),
    .err_port (err_port)
);

// File: tb/mgmt_status_rx_bench.sv
`timescale 1ns/1ps
module mgmt_status_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_start = 1'b0;
    logic        cfg_crs_high = 1'b1;
    logic [5:0]  cfg_id0 = 6'd5;
    logic [5:0]  cfg_id1 = 6'd42;
    logic        mrx_clk = 1'b0;
    logic        mrx_data = 1'b0;
    logic        mrx_crs = 1'b0;
    logic        st_ready = 1'b1;
    logic        st_valid;
    logic [55:0] st_bytes;
    logic        st_sel;
    logic        err_bus;
    logic        err_port;

    always #2.5 clk = ~clk;

    mgmt_status_rx u_mgmt_status_rx (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_crs_high(cfg_crs_high),
        .cfg_id0(cfg_id0), .cfg_id1(cfg_id1), .mrx_clk(mrx_clk), .mrx_data(mrx_data),
        .mrx_crs(mrx_crs), .st_valid(st_valid), .st_ready(st_ready), .st_bytes(st_bytes),
        .st_sel(st_sel), .err_bus(err_bus), .err_port(err_port)
    );

    int checks = 0;
    int fails = 0;
    int bus_n = 0;
    int port_n = 0;
    int acc_n = 0;
    logic [55:0] acc_bytes = '0;
    logic        acc_sel = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (err_bus) bus_n++;
            if (err_port) port_n++;
            if (st_valid && st_ready) begin
                acc_n++;
                acc_bytes = st_bytes;
                acc_sel = st_sel;
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clr();
        bus_n = 0; port_n = 0; acc_n = 0;
    endtask

    task automatic sbit(input logic b);
        mrx_data = b;
        cyc(4);
        mrx_clk = 1'b1;
        cyc(4);
        mrx_clk = 1'b0;
    endtask

    task automatic sbyte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) sbit(v[i]);
    endtask

    function automatic logic [55:0] mk(input logic [5:0] id, input logic [3:0] port,
                                       input logic [15:0] oct, input logic [7:0] flg);
        return {8'h00, 8'h00, flg, oct[15:8], oct[7:0], 4'h0, port, 2'b00, id};
    endfunction

    task automatic frame_body(input bit sfd, input int ndata, input logic [55:0] st, input int nbits);
        mrx_crs = cfg_crs_high;
        cyc(8);
        sbyte(8'h55);
        sbyte(8'h55);
        if (sfd) sbyte(8'hD5);
        for (int i = 0; i < ndata; i++) sbyte(8'hA0 + 8'(i));
        for (int i = 0; i < nbits; i++) sbit(st[i]);
        cyc(8);
    endtask

    task automatic frame(input bit sfd, input int ndata, input logic [55:0] st, input int nbits);
        frame_body(sfd, ndata, st, nbits);
        mrx_crs = ~cfg_crs_high;
        cyc(14);
    endtask

    task automatic good_frame(input int ndata, input logic [55:0] st, input logic esel, input string tag);
        clr();
        frame(1'b1, ndata, st, 56);
        chk(acc_n == 1, tag, 64'(acc_n), 64'd1);
        chk(acc_bytes == st, tag, 64'(acc_bytes), 64'(st));
        chk(acc_sel == esel && bus_n == 0 && port_n == 0, tag,
            {acc_sel, 31'(bus_n + port_n)}, {esel, 31'd0});
    endtask

    initial begin
        logic [55:0] sa, sb;
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        // reset state (R10)
        chk(!st_valid && !err_bus && !err_port, "R10 reset", {st_valid, err_bus, err_port}, 0);
        cyc(4);
        cfg_start = 1'b1;
        cyc(4);

        // R1 R3: variable leading data bytes, trailing 56 bits kept
        for (int n = 0; n < 7; n++)
            good_frame(n, mk(6'd5, 4'(n), 16'h1234 + 16'(n * 977), 8'h3C ^ 8'(n)), 1'b0, "R3 trailing bytes");
        good_frame(2, mk(6'd5, 4'd1, 16'hFFFF, 8'hFF), 1'b0, "R1 rising-edge capture");

        // R6: sweep every ID
        for (int id = 0; id < 64; id++) begin
            clr();
            sa = mk(6'(id), 4'd3, 16'(id * 31), 8'h5A);
            frame(1'b1, 1, sa, 56);
            if (id == 5 || id == 42) begin
                chk(acc_n == 1 && acc_bytes == sa, "R6 matching id accepted", 64'(acc_n), 64'd1);
                chk(acc_sel == (id == 42), "R6 select index", 64'(acc_sel), 64'(id == 42));
            end else begin
                chk(acc_n == 0 && bus_n == 0 && port_n == 0, "R6 unmatched id dropped",
                    64'(acc_n + bus_n + port_n), 64'd0);
            end
        end
        // R6 priority when both IDs equal
        cfg_id1 = 6'd5;
        good_frame(0, mk(6'd5, 4'd2, 16'h0040, 8'h00), 1'b0, "R6 id0 priority");
        cfg_id1 = 6'd42;

        // R7: port sweep
        for (int p = 0; p < 16; p++) begin
            clr();
            sa = mk(6'd42, 4'(p), 16'h0100, 8'h01);
            frame(1'b1, 0, sa, 56);
            if (p <= 13)
                chk(acc_n == 1 && port_n == 0 && acc_bytes == sa, "R7 port in range", 64'(acc_n), 64'd1);
            else
                chk(acc_n == 0 && port_n == 1 && bus_n == 0, "R7 port out of range",
                    {32'(acc_n), 32'(port_n)}, {32'd0, 32'd1});
        end

        // R4: no delimiter
        clr();
        frame(1'b0, 0, 56'h0, 56);
        chk(bus_n == 1 && acc_n == 0, "R4 missing delimiter", {32'(bus_n), 32'(acc_n)}, {32'd1, 32'd0});

        // R5: short status
        clr();
        frame(1'b1, 0, mk(6'd5, 4'd1, 16'h0080, 8'h00), 55);
        chk(bus_n == 1 && acc_n == 0, "R5 short status", {32'(bus_n), 32'(acc_n)}, {32'd1, 32'd0});
        clr();
        frame(1'b1, 0, mk(6'd5, 4'd1, 16'h0080, 8'h00), 8);
        chk(bus_n == 1 && acc_n == 0, "R5 very short status", {32'(bus_n), 32'(acc_n)}, {32'd1, 32'd0});

        // R8: start disabled
        cfg_start = 1'b0;
        clr();
        frame(1'b1, 0, mk(6'd5, 4'd1, 16'h0080, 8'h00), 56);
        frame(1'b0, 0, 56'h0, 56);
        chk(acc_n == 0 && bus_n == 0 && port_n == 0 && !st_valid, "R8 start disabled",
            64'(acc_n + bus_n + port_n), 64'd0);

        // R2: active-low carrier
        cfg_crs_high = 1'b0;
        mrx_crs = 1'b1;
        cyc(8);
        cfg_start = 1'b1;
        cyc(4);
        for (int n = 0; n < 3; n++)
            good_frame(n, mk(6'd42, 4'(n + 7), 16'hBEEF - 16'(n), 8'h81), 1'b1, "R2 active-low carrier");
        cfg_start = 1'b0;
        cfg_crs_high = 1'b1;
        mrx_crs = 1'b0;
        cyc(8);
        cfg_start = 1'b1;
        cyc(4);
        good_frame(1, mk(6'd5, 4'd9, 16'h0203, 8'h10), 1'b0, "R2 active-high carrier");

        // R9: backpressure, second frame discarded
        st_ready = 1'b0;
        clr();
        sa = mk(6'd5, 4'd4, 16'h1111, 8'h22);
        sb = mk(6'd42, 4'd6, 16'h3333, 8'h44);
        frame(1'b1, 0, sa, 56);
        chk(st_valid && st_bytes == sa, "R9 held status", 64'(st_bytes), 64'(sa));
        frame(1'b1, 0, sb, 56);
        chk(st_valid && st_bytes == sa && st_sel == 1'b0 && acc_n == 0, "R9 new frame discarded",
            64'(st_bytes), 64'(sa));
        st_ready = 1'b1;
        cyc(3);
        chk(acc_n == 1 && acc_bytes == sa && !st_valid, "R9 held status accepted", 64'(acc_bytes), 64'(sa));

        // R9: acceptance and new-status load at every offset
        for (int k = 0; k < 7; k++) begin
            st_ready = 1'b0;
            clr();
            sa = mk(6'd5, 4'(k), 16'h0A00 + 16'(k), 8'h00);
            sb = mk(6'd42, 4'(k + 1), 16'h0B00 + 16'(k), 8'hF0);
            frame(1'b1, 0, sa, 56);
            frame_body(1'b1, 0, sb, 56);
            mrx_crs = ~cfg_crs_high;
            cyc(k);
            st_ready = 1'b1;
            cyc(1);
            st_ready = 1'b0;
            cyc(10);
            chk(acc_n == 1 && acc_bytes == sa, "R9 offset accept", 64'(acc_bytes), 64'(sa));
            if (k <= 3)
                chk(st_valid && st_bytes == sb && st_sel, "R9 same-cycle replace", 64'(st_bytes), 64'(sb));
            else
                chk(!st_valid, "R9 late accept drops new", 64'(st_valid), 64'd0);
            st_ready = 1'b1;
            cyc(3);
        end

        summary();
        $finish;
    end
endmodule